// File: doc/BRIEF.md
# Base 64-bit integer instruction decoder

This block takes one 32-bit instruction word from the base 64-bit integer instruction set and breaks it into the fields an execution stage needs. It reports whether the encoding is legal, an instruction class, an operation code, the three register index fields, a fully assembled 64-bit immediate and a write-enable for the destination register. Execution, the register file and memory are outside the block.

Instruction words flow in and decoded results flow out over valid/ready handshakes, with one register stage between them. A word is taken when `in_valid` and `in_ready` are both high. Its result appears on the outputs in the next cycle and stays there, unchanged, until the consumer takes it with `out_ready`. `in_ready` is high whenever the output stage is empty or is being drained in the same cycle, so back-pressure from the consumer travels straight back to the producer, and a full stream moves one word per cycle.

The block checks every field that the instruction set fixes: funct3 values that are not defined, funct7 and shift top bits, and the exact fence and system patterns. Anything that matches no defined pattern comes out as illegal with a neutral payload.

Top module: `rv64_inst_decoder`

## Requirements
- R1: After reset `out_valid` is 0 and `in_ready` is 1. A word taken on a rising edge (`in_valid` and `in_ready` both high) is presented with `out_valid` high after that edge. `in_ready` equals `!out_valid || out_ready`.
- R2: While `out_valid` is high and `out_ready` is low, every output field holds its value and `in_valid`/`in_inst` have no effect.
- R3: The major opcode in bits 6..0 selects the class: 0110111 and 0010111 upper-immediate (LUI, AUIPC, U immediate = bits 31..12 followed by twelve zeros, sign-extended); 1101111 jump; 1100111 jump-register (funct3 000 only); 1100011 branch; 0000011 load; 0100011 store; 0010011 ALU-immediate; 0110011 ALU-register; 0011011 word ALU-immediate; 0111011 word ALU-register; 0001111 fence; 1110011 system.
- R4: Branches map funct3 000/001/100/101/110/111 to BEQ/BNE/BLT/BGE/BLTU/BGEU, and 010/011 are illegal. The immediate puts bit 31 at bit 12, bit 7 at bit 11, bits 30..25 at bits 10..5 and bits 11..8 at bits 4..1, with bit 0 zero, and sign-extends the result to 64 bits.
- R5: The jump immediate puts bit 31 at bit 20, bits 19..12 at bits 19..12, bit 20 at bit 11 and bits 30..21 at bits 10..1, with bit 0 zero, sign-extended. Jump-register, loads, ALU-immediate, word add-immediate and fences use bits 31..20 sign-extended.
- R6: Loads map funct3 000..011 to signed byte/half/word/double and 100..110 to unsigned byte/half/word. Load funct3 111 is illegal. Stores map funct3 000..011 to byte..double, and funct3 with bit 2 set is illegal. The store immediate is bits 31..25 above bits 11..7, sign-extended.
- R7: ALU-immediate funct3 001 (shift left) needs bits 31..26 = 000000. Funct3 101 is a logical right shift with 000000 and an arithmetic right shift with 010000. Any other top pattern is illegal. For these shifts the immediate is the 6-bit amount in bits 25..20, zero-extended.
- R8: Word ALU-immediate allows only funct3 000 (add, I immediate), 001 (bits 31..25 = 0000000) and 101 (0000000 logical, 0100000 arithmetic). For word shifts the immediate is the 5-bit amount in bits 24..20, zero-extended.
- R9: In both register forms, funct7 0100000 selects subtract with funct3 000 and arithmetic right shift with funct3 101. Every other operation needs funct7 0000000. The word register form allows only funct3 000, 001 and 101. Register forms give a zero immediate.
- R10: A fence needs bits 31..28 and bits 19..7 to be zero, and its immediate is bits 31..20. The instruction-fence needs every bit above the opcode to be zero except funct3 = 001. A system word is a call when bits 31..7 are all zero (immediate 0), and a breakpoint when only bit 20 is set (immediate 1). Every other system word is illegal.
- R11: An illegal word gives `out_legal` 0, class NONE, operation NONE, an all-zero immediate and `out_wr_en` 0.
- R12: `out_rd`, `out_rs1` and `out_rs2` always carry bits 11..7, 19..15 and 24..20. `out_wr_en` is 1 only for a legal class that writes a register (upper, jump, jump-register, load, any ALU form) whose destination index is not 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Instruction word present |
| in_ready | output | 1 | Decoder can take a word this cycle |
| in_inst | input | 32 | Instruction word |
| out_valid | output | 1 | Decoded result present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_legal | output | 1 | Encoding matched a defined pattern |
| out_cls | output | 4 | Instruction class (package enum) |
| out_op | output | 6 | Operation (package enum) |
| out_rd | output | 5 | Destination index field |
| out_rs1 | output | 5 | First source index field |
| out_rs2 | output | 5 | Second source index field |
| out_imm | output | 64 | Assembled, extended immediate |
| out_wr_en | output | 1 | Destination write needed (never for index 0) |

## Verification
The assertions check on every cycle that an accepted word produces a valid output and that a stalled output holds still while blocking the input side. They also check that index 0 never carries a write-enable, that illegal results are neutral, that branch immediates are properly sign-extended and that shift amounts stay in range. Whether each bit pattern maps to the right class and operation, and whether each scrambled immediate is assembled bit for bit, can only be shown by the bench's directed encodings: these are built from known offsets and cover the edge values and the near-miss encodings that must be rejected.

// File: rtl/rvd_pkg.sv
package rvd_pkg;

  typedef enum logic [3:0] {
    CL_NONE, CL_UPPER, CL_JUMP, CL_JUMP_REG, CL_BRANCH, CL_LOAD, CL_STORE,
    CL_ALU_IMM, CL_ALU_REG, CL_ALU_IMM_W, CL_ALU_REG_W, CL_FENCE, CL_SYSTEM
  } iclass_e;

  typedef enum logic [5:0] {
    OP_NONE, OP_ADD, OP_SUB, OP_SLL, OP_SLT, OP_SLTU, OP_XOR, OP_SRL, OP_SRA,
    OP_OR, OP_AND, OP_BEQ, OP_BNE, OP_BLT, OP_BGE, OP_BLTU, OP_BGEU,
    OP_LB, OP_LH, OP_LW, OP_LD, OP_LBU, OP_LHU, OP_LWU,
    OP_SB, OP_SH, OP_SW, OP_SD, OP_LUI, OP_AUIPC, OP_JAL, OP_JALR,
    OP_FENCE, OP_FENCE_I, OP_ECALL, OP_EBREAK
  } iop_e;

  typedef enum logic [2:0] {
    IMM_NONE, IMM_I, IMM_S, IMM_B, IMM_U, IMM_J, IMM_SH6, IMM_SH5
  } ifmt_e;

  typedef struct packed {
    logic    legal;
    iclass_e cls;
    iop_e    op;
    ifmt_e   fmt;
    logic    writes_rd;
  } dec_ctl_t;

  localparam logic [6:0] OPC_LUI    = 7'b0110111;
  localparam logic [6:0] OPC_AUIPC  = 7'b0010111;
  localparam logic [6:0] OPC_JAL    = 7'b1101111;
  localparam logic [6:0] OPC_JALR   = 7'b1100111;
  localparam logic [6:0] OPC_BRANCH = 7'b1100011;
  localparam logic [6:0] OPC_LOAD   = 7'b0000011;
  localparam logic [6:0] OPC_STORE  = 7'b0100011;
  localparam logic [6:0] OPC_IMM    = 7'b0010011;
  localparam logic [6:0] OPC_REG    = 7'b0110011;
  localparam logic [6:0] OPC_IMM_W  = 7'b0011011;
  localparam logic [6:0] OPC_REG_W  = 7'b0111011;
  localparam logic [6:0] OPC_FENCE  = 7'b0001111;
  localparam logic [6:0] OPC_SYSTEM = 7'b1110011;

  localparam logic [6:0] F7_BASE = 7'b0000000;
  localparam logic [6:0] F7_ALT  = 7'b0100000;

endpackage

// File: rtl/rvd_imm_gen.sv
module rvd_imm_gen
  import rvd_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [31:7]     inst_hi,
  input  ifmt_e           fmt,
  output logic [XLEN-1:0] imm
);
  localparam int SX_I = XLEN - 12;
  localparam int SX_B = XLEN - 13;
  localparam int SX_U = XLEN - 32;
  localparam int SX_J = XLEN - 21;

  logic sgn;
  assign sgn = inst_hi[31];

  always_comb begin
    unique case (fmt)
      IMM_I:   imm = {{SX_I{sgn}}, inst_hi[31:20]};
      IMM_S:   imm = {{SX_I{sgn}}, inst_hi[31:25], inst_hi[11:7]};
      IMM_B:   imm = {{SX_B{sgn}}, sgn, inst_hi[7], inst_hi[30:25], inst_hi[11:8], 1'b0};
      IMM_U:   imm = {{SX_U{sgn}}, inst_hi[31:12], 12'h000};
      IMM_J:   imm = {{SX_J{sgn}}, sgn, inst_hi[19:12], inst_hi[20], inst_hi[30:21], 1'b0};
      IMM_SH6: imm = {{(XLEN-6){1'b0}}, inst_hi[25:20]};
      IMM_SH5: imm = {{(XLEN-5){1'b0}}, inst_hi[24:20]};
      default: imm = '0;
    endcase
  end
endmodule

// File: rtl/rvd_op_decode.sv
module rvd_op_decode
  import rvd_pkg::*;
(
  input  logic [31:0] inst,
  output dec_ctl_t    ctl
);
  logic [6:0] opc;
  logic [2:0] f3;
  logic [6:0] f7;
  assign opc = inst[6:0];
  assign f3  = inst[14:12];
  assign f7  = inst[31:25];

  function automatic iop_e alu_op(input logic [2:0] s, input logic alt);
    case (s)
      3'b000:  return alt ? OP_SUB : OP_ADD;
      3'b001:  return OP_SLL;
      3'b010:  return OP_SLT;
      3'b011:  return OP_SLTU;
      3'b100:  return OP_XOR;
      3'b101:  return alt ? OP_SRA : OP_SRL;
      3'b110:  return OP_OR;
      default: return OP_AND;
    endcase
  endfunction

  function automatic iop_e br_op(input logic [2:0] s);
    case (s)
      3'b000:  return OP_BEQ;
      3'b001:  return OP_BNE;
      3'b100:  return OP_BLT;
      3'b101:  return OP_BGE;
      3'b110:  return OP_BLTU;
      3'b111:  return OP_BGEU;
      default: return OP_NONE;
    endcase
  endfunction

  function automatic iop_e ld_op(input logic [2:0] s);
    case (s)
      3'b000:  return OP_LB;
      3'b001:  return OP_LH;
      3'b010:  return OP_LW;
      3'b011:  return OP_LD;
      3'b100:  return OP_LBU;
      3'b101:  return OP_LHU;
      3'b110:  return OP_LWU;
      default: return OP_NONE;
    endcase
  endfunction

  function automatic iop_e st_op(input logic [1:0] s);
    case (s)
      2'b00:   return OP_SB;
      2'b01:   return OP_SH;
      2'b10:   return OP_SW;
      default: return OP_SD;
    endcase
  endfunction

  // register-form funct7 rule shared by both widths
  logic reg_f7_ok, reg_alt;
  assign reg_alt   = (f7 == F7_ALT);
  assign reg_f7_ok = (f7 == F7_BASE) || (reg_alt && (f3 == 3'b000 || f3 == 3'b101));

  always_comb begin
    ctl = '{1'b0, CL_NONE, OP_NONE, IMM_NONE, 1'b0};
    case (opc)
      OPC_LUI:   ctl = '{1'b1, CL_UPPER, OP_LUI, IMM_U, 1'b1};
      OPC_AUIPC: ctl = '{1'b1, CL_UPPER, OP_AUIPC, IMM_U, 1'b1};
      OPC_JAL:   ctl = '{1'b1, CL_JUMP, OP_JAL, IMM_J, 1'b1};
      OPC_JALR:
        if (f3 == 3'b000) ctl = '{1'b1, CL_JUMP_REG, OP_JALR, IMM_I, 1'b1};
      OPC_BRANCH:
        if (f3[2:1] != 2'b01) ctl = '{1'b1, CL_BRANCH, br_op(f3), IMM_B, 1'b0};
      OPC_LOAD:
        if (f3 != 3'b111) ctl = '{1'b1, CL_LOAD, ld_op(f3), IMM_I, 1'b1};
      OPC_STORE:
        if (!f3[2]) ctl = '{1'b1, CL_STORE, st_op(f3[1:0]), IMM_S, 1'b0};
      OPC_IMM:
        if (f3 == 3'b001) begin
          if (inst[31:26] == 6'b000000) ctl = '{1'b1, CL_ALU_IMM, OP_SLL, IMM_SH6, 1'b1};
        end else if (f3 == 3'b101) begin
          if (inst[31:26] == 6'b000000)      ctl = '{1'b1, CL_ALU_IMM, OP_SRL, IMM_SH6, 1'b1};
          else if (inst[31:26] == 6'b010000) ctl = '{1'b1, CL_ALU_IMM, OP_SRA, IMM_SH6, 1'b1};
        end else begin
          ctl = '{1'b1, CL_ALU_IMM, alu_op(f3, 1'b0), IMM_I, 1'b1};
        end
      OPC_IMM_W:
        if (f3 == 3'b000) ctl = '{1'b1, CL_ALU_IMM_W, OP_ADD, IMM_I, 1'b1};
        else if (f3 == 3'b001 && f7 == F7_BASE)
          ctl = '{1'b1, CL_ALU_IMM_W, OP_SLL, IMM_SH5, 1'b1};
        else if (f3 == 3'b101 && (f7 == F7_BASE || f7 == F7_ALT))
          ctl = '{1'b1, CL_ALU_IMM_W, alu_op(f3, f7 == F7_ALT), IMM_SH5, 1'b1};
      OPC_REG:
        if (reg_f7_ok) ctl = '{1'b1, CL_ALU_REG, alu_op(f3, reg_alt), IMM_NONE, 1'b1};
      OPC_REG_W:
        if (reg_f7_ok && (f3 == 3'b000 || f3 == 3'b001 || f3 == 3'b101))
          ctl = '{1'b1, CL_ALU_REG_W, alu_op(f3, reg_alt), IMM_NONE, 1'b1};
      OPC_FENCE:
        if (inst[31:28] == 4'h0 && inst[19:7] == 13'h0)
          ctl = '{1'b1, CL_FENCE, OP_FENCE, IMM_I, 1'b0};
        else if (inst[31:15] == 17'h0 && f3 == 3'b001 && inst[11:7] == 5'h0)
          ctl = '{1'b1, CL_FENCE, OP_FENCE_I, IMM_I, 1'b0};
      OPC_SYSTEM:
        if (inst[31:7] == 25'h0)         ctl = '{1'b1, CL_SYSTEM, OP_ECALL, IMM_I, 1'b0};
        else if (inst[31:7] == 25'h2000) ctl = '{1'b1, CL_SYSTEM, OP_EBREAK, IMM_I, 1'b0};
      default: ;
    endcase
  end
endmodule

// File: rtl/rv64_inst_decoder.sv
module rv64_inst_decoder
  import rvd_pkg::*;
#(
  parameter int XLEN    = 64,
  parameter bit OUT_REG = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [31:0]     in_inst,
  output logic            out_valid,
  input  logic            out_ready,
  output logic            out_legal,
  output logic [3:0]      out_cls,
  output logic [5:0]      out_op,
  output logic [4:0]      out_rd,
  output logic [4:0]      out_rs1,
  output logic [4:0]      out_rs2,
  output logic [XLEN-1:0] out_imm,
  output logic            out_wr_en
);
  typedef struct packed {
    logic            legal;
    iclass_e         cls;
    iop_e            op;
    logic [4:0]      rd;
    logic [4:0]      rs1;
    logic [4:0]      rs2;
    logic [XLEN-1:0] imm;
    logic            wr_en;
  } res_t;

  dec_ctl_t        ctl;
  logic [XLEN-1:0] imm_d;
  res_t            res_d, res_o;
  logic            vld_o;

  rvd_op_decode u_op (.inst(in_inst), .ctl(ctl));

  rvd_imm_gen #(.XLEN(XLEN)) u_imm (
    .inst_hi(in_inst[31:7]), .fmt(ctl.fmt), .imm(imm_d)
  );

  always_comb begin
    res_d.legal = ctl.legal;
    res_d.cls   = ctl.cls;
    res_d.op    = ctl.op;
    res_d.rd    = in_inst[11:7];
    res_d.rs1   = in_inst[19:15];
    res_d.rs2   = in_inst[24:20];
    res_d.imm   = imm_d;
    res_d.wr_en = ctl.writes_rd && (in_inst[11:7] != 5'd0);
  end

  generate
    if (OUT_REG) begin : g_reg
      res_t res_q;
      logic vld_q;

      assign in_ready = !vld_q || out_ready;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        vld_q <= 1'b0;
        else if (in_ready) vld_q <= in_valid;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                    res_q <= '0;
        else if (in_valid && in_ready) res_q <= res_d;
      end

      assign vld_o = vld_q;
      assign res_o = res_q;

      AST_ACCEPT_SHOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready |=> out_valid); // R1
      AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |-> !in_ready); // R1
      AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable({out_legal, out_cls, out_op,
          out_rd, out_rs1, out_rs2, out_imm, out_wr_en})); // R2
    end else begin : g_comb
      assign in_ready = out_ready;
      assign vld_o    = in_valid;
      assign res_o    = res_d;
    end
  endgenerate

  assign out_valid = vld_o;
  assign out_legal = res_o.legal;
  assign out_cls   = res_o.cls;
  assign out_op    = res_o.op;
  assign out_rd    = res_o.rd;
  assign out_rs1   = res_o.rs1;
  assign out_rs2   = res_o.rs2;
  assign out_imm   = res_o.imm;
  assign out_wr_en = res_o.wr_en;

  AST_X0_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_rd == 5'd0 |-> !out_wr_en); // R12
  AST_REJECT_NEUTRAL: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_legal |-> !out_wr_en && out_imm == '0 && out_op == OP_NONE
      && out_cls == CL_NONE); // R11
  AST_BRANCH_SEXT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_cls == CL_BRANCH |->
      ($countones(out_imm[XLEN-1:12]) == 0 || $countones(out_imm[XLEN-1:12]) == XLEN-12)); // R4
  AST_SHAMT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_cls == CL_ALU_IMM_W && out_op != OP_ADD |-> out_imm < 32); // R8
endmodule

// File: tb/rv64_inst_decoder_bench.sv
`timescale 1ns/1ps
module rv64_inst_decoder_bench;
  import rvd_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_inst = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic        out_legal;
  logic [3:0]  out_cls;
  logic [5:0]  out_op;
  logic [4:0]  out_rd, out_rs1, out_rs2;
  logic [63:0] out_imm;
  logic        out_wr_en;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  rv64_inst_decoder u_rv64_inst_decoder (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_inst(in_inst), .out_valid(out_valid), .out_ready(out_ready),
    .out_legal(out_legal), .out_cls(out_cls), .out_op(out_op), .out_rd(out_rd),
    .out_rs1(out_rs1), .out_rs2(out_rs2), .out_imm(out_imm), .out_wr_en(out_wr_en)
  );

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // encoders built from the field layouts in the requirements
  function automatic logic [31:0] enc_i(logic [11:0] imm, logic [4:0] rs1,
      logic [2:0] f3, logic [4:0] rd, logic [6:0] opc);
    return {imm, rs1, f3, rd, opc};
  endfunction
  function automatic logic [31:0] enc_r(logic [6:0] f7, logic [4:0] rs2,
      logic [4:0] rs1, logic [2:0] f3, logic [4:0] rd, logic [6:0] opc);
    return {f7, rs2, rs1, f3, rd, opc};
  endfunction
  function automatic logic [31:0] enc_s(logic [11:0] imm, logic [4:0] rs2,
      logic [4:0] rs1, logic [2:0] f3);
    return {imm[11:5], rs2, rs1, f3, imm[4:0], 7'b0100011};
  endfunction
  function automatic logic [31:0] enc_b(logic [12:0] off, logic [4:0] rs2,
      logic [4:0] rs1, logic [2:0] f3);
    return {off[12], off[10:5], rs2, rs1, f3, off[4:1], off[11], 7'b1100011};
  endfunction
  function automatic logic [31:0] enc_j(logic [20:0] off, logic [4:0] rd);
    return {off[20], off[10:1], off[11], off[19:12], rd, 7'b1101111};
  endfunction

  task automatic send(input logic [31:0] inst);
    @(negedge clk);
    in_inst  = inst;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic expect_ok(input string req, input logic [31:0] inst,
      input iclass_e cls, input iop_e op, input logic [63:0] imm, input logic wr);
    send(inst);
    chk(req, "valid", 64'(out_valid), 64'd1);
    chk(req, "legal", 64'(out_legal), 64'd1);
    chk(req, "class", 64'(out_cls), 64'(cls));
    chk(req, "op", 64'(out_op), 64'(op));
    chk(req, "imm", out_imm, imm);
    chk(req, "wr_en", 64'(out_wr_en), 64'(wr));
  endtask

  task automatic expect_bad(input string req, input logic [31:0] inst);
    send(inst);
    chk(req, "valid", 64'(out_valid), 64'd1);
    chk(req, "legal", 64'(out_legal), 64'd0);
    chk({req, "/R11"}, "class", 64'(out_cls), 64'(CL_NONE));
    chk({req, "/R11"}, "op", 64'(out_op), 64'(OP_NONE));
    chk({req, "/R11"}, "imm", out_imm, 64'd0);
    chk({req, "/R11"}, "wr_en", 64'(out_wr_en), 64'd0);
  endtask

  task automatic t_reset;
    chk("R1", "reset out_valid", 64'(out_valid), 64'd0);
    chk("R1", "reset in_ready", 64'(in_ready), 64'd1);
  endtask

  task automatic t_upper;
    expect_ok("R3", {20'h80001, 5'd5, OPC_LUI}, CL_UPPER, OP_LUI, 64'hFFFF_FFFF_8000_1000, 1'b1);
    expect_ok("R3/R12", {20'h12345, 5'd0, OPC_AUIPC}, CL_UPPER, OP_AUIPC, 64'h1234_5000, 1'b0);
  endtask

  task automatic t_jumps;
    expect_ok("R5", enc_j(21'(-4), 5'd1), CL_JUMP, OP_JAL, 64'(-4), 1'b1);
    expect_ok("R5", enc_j(21'(-1048576), 5'd1), CL_JUMP, OP_JAL, 64'(-1048576), 1'b1);
    expect_ok("R5", enc_j(21'h0AAAAA, 5'd3), CL_JUMP, OP_JAL, 64'h0AAAAA, 1'b1);
    expect_ok("R5", enc_i(12'hFFF, 5'd2, 3'b000, 5'd1, OPC_JALR), CL_JUMP_REG, OP_JALR, 64'(-1), 1'b1);
    expect_bad("R3", enc_i(12'h004, 5'd2, 3'b001, 5'd1, OPC_JALR));
  endtask

  task automatic t_branches;
    expect_ok("R4", enc_b(13'(-4096), 5'd2, 5'd1, 3'b000), CL_BRANCH, OP_BEQ, 64'(-4096), 1'b0);
    expect_ok("R4", enc_b(13'd4094, 5'd2, 5'd1, 3'b001), CL_BRANCH, OP_BNE, 64'd4094, 1'b0);
    expect_ok("R4", enc_b(13'd2048, 5'd2, 5'd1, 3'b100), CL_BRANCH, OP_BLT, 64'd2048, 1'b0);
    expect_ok("R4", enc_b(13'h0AAA, 5'd2, 5'd1, 3'b101), CL_BRANCH, OP_BGE, 64'h0AAA, 1'b0);
    expect_ok("R4", enc_b(13'(-2), 5'd2, 5'd1, 3'b110), CL_BRANCH, OP_BLTU, 64'(-2), 1'b0);
    expect_ok("R4", enc_b(13'h0554, 5'd2, 5'd1, 3'b111), CL_BRANCH, OP_BGEU, 64'h0554, 1'b0);
    expect_bad("R4", enc_b(13'd8, 5'd2, 5'd1, 3'b010));
  endtask

  task automatic t_mem;
    expect_ok("R6", enc_i(12'hFF8, 5'd4, 3'b011, 5'd7, OPC_LOAD), CL_LOAD, OP_LD, 64'(-8), 1'b1);
    expect_ok("R6", enc_i(12'h7FF, 5'd4, 3'b110, 5'd7, OPC_LOAD), CL_LOAD, OP_LWU, 64'h7FF, 1'b1);
    expect_ok("R6", enc_i(12'h001, 5'd4, 3'b100, 5'd7, OPC_LOAD), CL_LOAD, OP_LBU, 64'd1, 1'b1);
    expect_bad("R6", enc_i(12'h000, 5'd4, 3'b111, 5'd7, OPC_LOAD));
    expect_ok("R6", enc_s(12'h800, 5'd9, 5'd4, 3'b011), CL_STORE, OP_SD, 64'(-2048), 1'b0);
    expect_ok("R6", enc_s(12'h5A5, 5'd9, 5'd4, 3'b001), CL_STORE, OP_SH, 64'h5A5, 1'b0);
    expect_bad("R6", enc_s(12'h010, 5'd9, 5'd4, 3'b100));
  endtask

  task automatic t_alu_imm;
    expect_ok("R5", enc_i(12'hFFF, 5'd1, 3'b000, 5'd2, OPC_IMM), CL_ALU_IMM, OP_ADD, 64'(-1), 1'b1);
    expect_ok("R5", enc_i(12'h800, 5'd1, 3'b011, 5'd2, OPC_IMM), CL_ALU_IMM, OP_SLTU, 64'(-2048), 1'b1);
    expect_ok("R7", enc_i({6'b000000, 6'd63}, 5'd1, 3'b001, 5'd2, OPC_IMM), CL_ALU_IMM, OP_SLL, 64'd63, 1'b1);
    expect_ok("R7", enc_i({6'b010000, 6'd40}, 5'd1, 3'b101, 5'd2, OPC_IMM), CL_ALU_IMM, OP_SRA, 64'd40, 1'b1);
    expect_ok("R7", enc_i({6'b000000, 6'd33}, 5'd1, 3'b101, 5'd2, OPC_IMM), CL_ALU_IMM, OP_SRL, 64'd33, 1'b1);
    expect_bad("R7", enc_i({6'b000001, 6'd3}, 5'd1, 3'b101, 5'd2, OPC_IMM));
    expect_bad("R7", enc_i({6'b010000, 6'd3}, 5'd1, 3'b001, 5'd2, OPC_IMM));
    expect_ok("R8", enc_i(12'h800, 5'd1, 3'b000, 5'd2, OPC_IMM_W), CL_ALU_IMM_W, OP_ADD, 64'(-2048), 1'b1);
    expect_ok("R8", enc_r(F7_ALT, 5'd31, 5'd1, 3'b101, 5'd2, OPC_IMM_W), CL_ALU_IMM_W, OP_SRA, 64'd31, 1'b1);
    expect_bad("R8", enc_r(7'b0000001, 5'd3, 5'd1, 3'b001, 5'd2, OPC_IMM_W));
    expect_bad("R8", enc_i(12'h001, 5'd1, 3'b010, 5'd2, OPC_IMM_W));
  endtask

  task automatic t_alu_reg;
    expect_ok("R9", enc_r(F7_BASE, 5'd3, 5'd2, 3'b000, 5'd1, OPC_REG), CL_ALU_REG, OP_ADD, 64'd0, 1'b1);
    chk("R12", "rd", 64'(out_rd), 64'd1);
    chk("R12", "rs1", 64'(out_rs1), 64'd2);
    chk("R12", "rs2", 64'(out_rs2), 64'd3);
    expect_ok("R9", enc_r(F7_ALT, 5'd30, 5'd17, 3'b000, 5'd29, OPC_REG), CL_ALU_REG, OP_SUB, 64'd0, 1'b1);
    chk("R12", "rs2", 64'(out_rs2), 64'd30);
    expect_ok("R9", enc_r(F7_ALT, 5'd3, 5'd2, 3'b101, 5'd1, OPC_REG), CL_ALU_REG, OP_SRA, 64'd0, 1'b1);
    expect_ok("R9/R12", enc_r(F7_BASE, 5'd3, 5'd2, 3'b111, 5'd0, OPC_REG), CL_ALU_REG, OP_AND, 64'd0, 1'b0);
    expect_bad("R9", enc_r(F7_ALT, 5'd3, 5'd2, 3'b010, 5'd1, OPC_REG));
    expect_bad("R9", enc_r(7'b0000001, 5'd3, 5'd2, 3'b000, 5'd1, OPC_REG));
    expect_ok("R9", enc_r(F7_ALT, 5'd3, 5'd2, 3'b000, 5'd1, OPC_REG_W), CL_ALU_REG_W, OP_SUB, 64'd0, 1'b1);
    expect_ok("R9", enc_r(F7_BASE, 5'd3, 5'd2, 3'b001, 5'd1, OPC_REG_W), CL_ALU_REG_W, OP_SLL, 64'd0, 1'b1);
    expect_bad("R9", enc_r(F7_BASE, 5'd3, 5'd2, 3'b100, 5'd1, OPC_REG_W));
  endtask

  task automatic t_system;
    expect_ok("R10", 32'h0FF0_000F, CL_FENCE, OP_FENCE, 64'h0FF, 1'b0);
    expect_bad("R10", 32'h0FF0_800F);
    expect_bad("R10", 32'h1000_000F);
    expect_ok("R10", 32'h0000_100F, CL_FENCE, OP_FENCE_I, 64'd0, 1'b0);
    expect_bad("R10", 32'h0000_108F);
    expect_ok("R10", 32'h0000_0073, CL_SYSTEM, OP_ECALL, 64'd0, 1'b0);
    expect_ok("R10", 32'h0010_0073, CL_SYSTEM, OP_EBREAK, 64'd1, 1'b0);
    expect_bad("R10", 32'h0020_0073);
    expect_bad("R10", 32'h0000_00F3);
  endtask

  task automatic t_bad_opcode;
    expect_bad("R3", 32'h0000_0000);
    expect_bad("R3", 32'hFFFF_FFFF);
  endtask

  task automatic t_backpressure;
    logic [31:0] a, b;
    a = enc_i(12'h123, 5'd1, 3'b000, 5'd2, OPC_IMM);
    b = enc_r(F7_BASE, 5'd3, 5'd2, 3'b100, 5'd4, OPC_REG);
    @(negedge clk);
    out_ready = 1'b0;
    in_inst   = a;
    in_valid  = 1'b1;
    @(negedge clk);
    chk("R1", "valid after accept", 64'(out_valid), 64'd1);
    chk("R1", "in_ready while stalled", 64'(in_ready), 64'd0);
    in_inst = b;
    @(negedge clk);
    chk("R2", "held op", 64'(out_op), 64'(OP_ADD));
    chk("R2", "held imm", out_imm, 64'h123);
    chk("R2", "held rd", 64'(out_rd), 64'd2);
    out_ready = 1'b1;
    @(negedge clk);
    chk("R1", "next word op", 64'(out_op), 64'(OP_XOR));
    chk("R1", "next word valid", 64'(out_valid), 64'd1);
    in_valid = 1'b0;
    @(negedge clk);
    chk("R1", "drained", 64'(out_valid), 64'd0);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #1;
    t_reset;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_upper;
    t_jumps;
    t_branches;
    t_mem;
    t_alu_imm;
    t_alu_reg;
    t_system;
    t_bad_opcode;
    t_backpressure;
    finish_run;
  end

  initial begin
    #100000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run;
  end
endmodule